// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the configuration header of a single-function PCI endpoint. It is reached through a plain dword-addressed port: a write strobe, a 6-bit dword address, four byte enables and 32-bit write data. Read data is a combinational function of the address. The header carries these registers:
- constant identification fields;
- a command register whose writable bits are set by a parameter;
- a status register whose error bits are set by event inputs and cleared by writing ones;
- a row of up to six base address registers (BARs).

Each BAR slot is configured by parameter as unused, I/O, 32-bit memory or 64-bit memory, with a power-of-two region size and a prefetchable flag. Configuration software sizes a region by writing all ones and reading back. Address bits below the region size are not writable, so the readback shows the size mask along with fixed type bits. For each slot the block drives out a decoded base address, a region size and a decode enable that follows the command register. It also pulses a one-cycle remap strobe when an enabled region moves.

Top module: `cfg_header_regs`

## Requirements
- R1: Dword 0 reads {device ID, vendor ID}. Dword 2 reads {class code[23:0], revision}: byte 09h is the programming interface, 0Ah the sub-class and 0Bh the base class. Dword 3 reads 0, so the header-type byte at 0Eh is 00h. Writes to dwords 0, 2 and 3 change nothing.
- R2: The command register (dword 1, bits [15:0]) resets to 0. Its writable bits are the parameter mask ANDed with 0x03FF. Bits 10 to 15 always read 0.
- R3: Command bit 0 drives the I/O decode enable and the enable of every I/O BAR. Bit 1 drives the memory decode enable and the enable of every memory BAR. Bit 2 drives the bus-master enable. Unused slots are never enabled.
- R4: The status register (dword 1, bits [31:16]) resets to a parameter value. Its writable bits are the parameter mask ANDed with 0xFF90. Writing 1 to a writable bit clears it. Writing 0 leaves it unchanged. Non-writable bits never change from writes.
- R5: Event input bits 0 to 5 set status bits 8, 11, 12, 13, 14 and 15 at the next clock edge. If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: An I/O BAR reads bit 0 as 1 and bit 1 as 0. Bits below log2(region size) read 0, so after an all-ones write it reads the size mask with 1 in bit 0.
- R7: A 32-bit memory BAR reads bits [2:0] as 000, and bit 3 as 1 only if it is prefetchable. After an all-ones write it reads the size mask with these type bits.
- R8: A 64-bit memory BAR reads bits [2:1] as 10 and bit 3 as its prefetch flag. The next dword holds address bits [63:32], and the bits of that dword below the region size read 0.
- R9: Reads of dword 3 and of every dword past the last BAR slot return 0, and writes to them are discarded.
- R10: A BAR dword updates the decoded base output only when all four of its bytes have been written, over one or more writes. If that update changes the base while the region is enabled, the region's remap output is high for exactly the following cycle. Otherwise no remap pulse occurs.
- R11: Each write changes only the bytes whose byte enable is set. A write to the command bytes leaves status untouched, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the addressed dword |
| cfg_addr | input | 6 | Dword address within the 256-byte header space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| err_evt | input | 6 | Error events: parity data, signaled target abort, received target abort, received master abort, signaled system error, detected parity |
| io_decode_en | output | 1 | Command bit 0 |
| mem_decode_en | output | 1 | Command bit 1 |
| master_en | output | 1 | Command bit 2 |
| region_en | output | NB | Per-slot decode enable |
| region_remap | output | NB | Per-slot one-cycle remap strobe |
| region_base | output | 64*NB | Per-slot decoded base address |
| region_size | output | 64*NB | Per-slot region size in bytes (0 for unused slots) |

## Verification
The bench builds six slots: one I/O slot of 32 bytes, two 32-bit memory slots (4 KiB not prefetchable, 64 KiB prefetchable), one 64-bit prefetchable slot of 16 GiB with its upper half in the next slot, and one unused slot. With this set, a single run reaches every type-bit pattern, an upper dword with non-writable low bits, and an unused slot. The command mask 0xFC37 puts masked bits both inside and outside the 0x03FF window. The status mask 0xF900 leaves the capability bits, the DEVSEL field and the 66 MHz bit read-only. This allows sweeps over every command bit, every command value that affects decode, every event input and every unused dword.

// File: rtl/cfghdr_pkg.sv
// Package: shared constants, BAR slot kinds and helper functions for the
// configuration header register file.
// Assumes: status event inputs are ordered as documented in evt_bits().
package cfghdr_pkg;

    typedef enum logic [1:0] {
        BAR_NONE  = 2'd0,
        BAR_IO    = 2'd1,
        BAR_MEM32 = 2'd2,
        BAR_MEM64 = 2'd3
    } bar_kind_e;

    // Bits of command and status that may ever be writable.
    localparam logic [15:0] CMD_IMPL_MASK  = 16'h03FF;
    localparam logic [15:0] STAT_IMPL_MASK = 16'hFF90;

    localparam int NUM_EVT  = 6;
    localparam int DW_BYTES = 4;

    // Map error event inputs onto status bit positions 8, 11..15.
    function automatic logic [15:0] evt_bits(input logic [NUM_EVT-1:0] evt);
        logic [15:0] m;
        m = '0;
        m[8] = evt[0];
        for (int k = 1; k < NUM_EVT; k++) begin
            m[10+k] = evt[k];
        end
        return m;
    endfunction

    // Expand four byte enables into a 32-bit bit mask.
    function automatic logic [31:0] be_expand(input logic [DW_BYTES-1:0] be);
        logic [31:0] m;
        for (int b = 0; b < DW_BYTES; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
// Module: command and status registers (dword 1 of the header).
// Command: masked read/write, limited to bits [9:0].
// Status: write-one-to-clear on masked bits; events set bits, set wins.
// Assumes: wr is already qualified by the dword-1 address decode.
module cfg_cmd_stat
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] CMD_WMASK  = 16'h03FF,
    parameter logic [15:0] STAT_INIT  = 16'h0000,
    parameter logic [15:0] STAT_WMASK = 16'hFF90
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [3:0]         be,
    input  logic [31:0]        wdata,
    input  logic [NUM_EVT-1:0] err_evt,
    output logic [15:0]        cmd_q,
    output logic [15:0]        stat_q
);

    localparam logic [15:0] CMD_WM  = CMD_WMASK & CMD_IMPL_MASK;
    localparam logic [15:0] STAT_WM = STAT_WMASK & STAT_IMPL_MASK;

    logic [31:0] bmask;
    logic [15:0] cmd_m;
    logic [15:0] cmd_nx;
    logic [15:0] stat_clr;
    logic [15:0] stat_set;
    logic [15:0] stat_nx;

    // Next-state for both registers from the write and the events.
    always_comb begin
        bmask    = be_expand(be);
        cmd_m    = wr ? (CMD_WM & bmask[15:0]) : 16'h0000;
        cmd_nx   = (cmd_q & ~cmd_m) | (wdata[15:0] & cmd_m);
        stat_clr = wr ? (wdata[31:16] & bmask[31:16] & STAT_WM) : 16'h0000;
        stat_set = evt_bits(err_evt);
        stat_nx  = (stat_q & ~stat_clr) | stat_set;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= 16'h0000;
            stat_q <= STAT_INIT;
        end else begin
            cmd_q  <= cmd_nx;
            stat_q <= stat_nx;
        end
    end

    assert_cmd_unwritable_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_WM) == 16'h0000);

    assert_stat_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && be[2] && be[3] && (err_evt == '0))
        |=> ((stat_q & $past(wdata[31:16] & STAT_WM)) == 16'h0000));

    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt != '0) |=> ((stat_q & $past(evt_bits(err_evt))) == $past(evt_bits(err_evt))));

endmodule

// File: rtl/cfg_bar_slot.sv
// Module: one base address register slot.
// Holds the raw writable address bits and a published decoded base that
// updates once all four bytes of a dword have been written. A 64-bit slot
// also owns the following dword (wr_hi) for address bits [63:32].
// Assumes: LOG2SZ >= 2 for I/O, 4..31 for 32-bit memory, >= 4 for 64-bit.
module cfg_bar_slot
    import cfghdr_pkg::*;
#(
    parameter logic [1:0] KIND   = BAR_MEM32,
    parameter int         LOG2SZ = 12,
    parameter logic       PREF   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        io_en,
    input  logic        mem_en,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi,
    output logic        region_en,
    output logic        region_remap,
    output logic [63:0] region_base,
    output logic [63:0] region_size
);

    localparam logic        IS_IO  = (KIND == BAR_IO);
    localparam logic        IS_64  = (KIND == BAR_MEM64);
    localparam logic        IS_MEM = (KIND == BAR_MEM32) || IS_64;
    localparam logic [63:0] LOW_MASK = (64'd1 << LOG2SZ) - 64'd1;
    localparam logic [63:0] ADDR_WM  = (KIND == BAR_NONE) ? 64'd0 :
                                       IS_64 ? ~LOW_MASK :
                                       (~LOW_MASK & 64'h0000_0000_FFFF_FFFF);
    localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 :
                                        IS_MEM ? {28'd0, PREF, IS_64, 2'b00} : 32'h0;

    logic [31:0] lo_q, hi_q;
    logic [31:0] lo_nx, hi_nx;
    logic [31:0] bmask;
    logic [3:0]  acc_lo, acc_hi;
    logic        done_lo, done_hi;
    logic [63:0] pub_q, pub_nx;
    logic        remap_q;

    // Masked byte-lane merge for both dwords and completion detect.
    always_comb begin
        bmask   = be_expand(be);
        lo_nx   = (lo_q & ~(ADDR_WM[31:0] & bmask)) | (wdata & ADDR_WM[31:0] & bmask);
        hi_nx   = (hi_q & ~(ADDR_WM[63:32] & bmask)) | (wdata & ADDR_WM[63:32] & bmask);
        done_lo = wr_lo && ((acc_lo | be) == 4'hF);
        done_hi = IS_64 && wr_hi && ((acc_hi | be) == 4'hF);
        pub_nx  = {(wr_hi ? hi_nx : hi_q), (wr_lo ? lo_nx : lo_q)} & ADDR_WM;
    end

    // Low dword storage, byte tracking, published base and remap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= 32'd0;
            acc_lo  <= 4'd0;
            acc_hi  <= 4'd0;
            pub_q   <= 64'd0;
            remap_q <= 1'b0;
        end else begin
            if (wr_lo) begin
                lo_q   <= lo_nx;
                acc_lo <= done_lo ? 4'd0 : (acc_lo | be);
            end
            if (wr_hi) begin
                acc_hi <= done_hi ? 4'd0 : (acc_hi | be);
            end
            if (done_lo || done_hi) begin
                pub_q <= pub_nx;
            end
            remap_q <= (done_lo || done_hi) && region_en && (pub_nx != pub_q);
        end
    end

    // Upper dword storage exists only for a 64-bit slot.
    if (IS_64) begin : g_hi
        // Upper address dword register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= 32'd0;
            end else if (wr_hi) begin
                hi_q <= hi_nx;
            end
        end
    end else begin : g_no_hi
        assign hi_q = 32'd0;
    end

    assign rd_lo        = (lo_q & ADDR_WM[31:0]) | TYPE_BITS;
    assign rd_hi        = hi_q & ADDR_WM[63:32];
    assign region_en    = IS_IO ? io_en : (IS_MEM ? mem_en : 1'b0);
    assign region_remap = remap_q;
    assign region_base  = pub_q;
    assign region_size  = (KIND == BAR_NONE) ? 64'd0 : (64'd1 << LOG2SZ);

    assert_remap_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        region_remap |-> region_en);

    assert_remap_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        region_remap |-> $past(wr_lo || wr_hi));

    assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region_base & ~ADDR_WM) == 64'd0);

endmodule

// File: rtl/cfg_header_regs.sv
// Module: type-0 configuration header register file, top level.
// Decodes the dword address, routes writes to the command/status pair and
// to the BAR slots, and builds the combinational read data.
// Assumes: a 64-bit BAR slot is followed by a slot configured BAR_NONE,
// which then serves as its upper dword.
module cfg_header_regs
    import cfghdr_pkg::*;
#(
    parameter logic [15:0]     VENDOR_ID  = 16'h1AB3,
    parameter logic [15:0]     DEVICE_ID  = 16'h7C21,
    parameter logic [7:0]      REVISION   = 8'h05,
    parameter logic [23:0]     CLASS_CODE = 24'h020000,
    parameter logic [15:0]     CMD_WMASK  = 16'hFC37,
    parameter logic [15:0]     STAT_INIT  = 16'h02B0,
    parameter logic [15:0]     STAT_WMASK = 16'hF900,
    parameter int              NB         = 6,
    parameter logic [2*NB-1:0] BAR_KIND   = 12'h239,
    parameter logic [6*NB-1:0] BAR_LOG2   = {6'd0, 6'd16, 6'd0, 6'd34, 6'd12, 6'd5},
    parameter logic [NB-1:0]   BAR_PREF   = 6'b010100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [5:0]         cfg_addr,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_EVT-1:0] err_evt,
    output logic               io_decode_en,
    output logic               mem_decode_en,
    output logic               master_en,
    output logic [NB-1:0]      region_en,
    output logic [NB-1:0]      region_remap,
    output logic [64*NB-1:0]   region_base,
    output logic [64*NB-1:0]   region_size
);

    localparam int AW           = 6;
    localparam int DW_ID        = 0;
    localparam int DW_CMDSTAT   = 1;
    localparam int DW_CLASS     = 2;
    localparam int FIRST_BAR_DW = 4;
    localparam int LAST_BAR_DW  = FIRST_BAR_DW + NB - 1;

    logic [15:0] cmd_q, stat_q;
    logic        wr_cs;
    logic [NB-1:0] wr_lo_w, wr_hi_w;
    logic [31:0] rd_lo_w [NB];
    logic [31:0] rd_hi_w [NB];
    logic [31:0] bar_rd_w [NB];

    assign wr_cs = cfg_wr && (cfg_addr == AW'(DW_CMDSTAT));

    cfg_cmd_stat #(
        .CMD_WMASK (CMD_WMASK),
        .STAT_INIT (STAT_INIT),
        .STAT_WMASK(STAT_WMASK)
    ) u_cmd_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_cs),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .err_evt(err_evt),
        .cmd_q  (cmd_q),
        .stat_q (stat_q)
    );

    assign io_decode_en  = cmd_q[0];
    assign mem_decode_en = cmd_q[1];
    assign master_en     = cmd_q[2];

    for (genvar i = 0; i < NB; i++) begin : g_slot
        assign wr_lo_w[i] = cfg_wr && (cfg_addr == AW'(FIRST_BAR_DW + i));
        if (i < NB - 1) begin : g_hi_wr
            assign wr_hi_w[i] = cfg_wr && (cfg_addr == AW'(FIRST_BAR_DW + i + 1));
        end else begin : g_no_hi_wr
            assign wr_hi_w[i] = 1'b0;
        end

        cfg_bar_slot #(
            .KIND  (BAR_KIND[2*i +: 2]),
            .LOG2SZ(int'(BAR_LOG2[6*i +: 6])),
            .PREF  (BAR_PREF[i])
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_lo       (wr_lo_w[i]),
            .wr_hi       (wr_hi_w[i]),
            .be          (cfg_be),
            .wdata       (cfg_wdata),
            .io_en       (cmd_q[0]),
            .mem_en      (cmd_q[1]),
            .rd_lo       (rd_lo_w[i]),
            .rd_hi       (rd_hi_w[i]),
            .region_en   (region_en[i]),
            .region_remap(region_remap[i]),
            .region_base (region_base[64*i +: 64]),
            .region_size (region_size[64*i +: 64])
        );

        if (i == 0) begin : g_rd_first
            assign bar_rd_w[i] = rd_lo_w[i];
        end else begin : g_rd_rest
            assign bar_rd_w[i] = rd_lo_w[i] | rd_hi_w[i-1];
        end
    end

    // Read data multiplexer; unimplemented dwords return zero.
    always_comb begin
        cfg_rdata = 32'd0;
        if (cfg_addr == AW'(DW_ID)) begin
            cfg_rdata = {DEVICE_ID, VENDOR_ID};
        end else if (cfg_addr == AW'(DW_CMDSTAT)) begin
            cfg_rdata = {stat_q, cmd_q};
        end else if (cfg_addr == AW'(DW_CLASS)) begin
            cfg_rdata = {CLASS_CODE, REVISION};
        end else begin
            for (int j = 0; j < NB; j++) begin
                if (cfg_addr == AW'(FIRST_BAR_DW + j)) begin
                    cfg_rdata = bar_rd_w[j];
                end
            end
        end
    end

    assert_reserved_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_addr == AW'(3)) || (int'(cfg_addr) > LAST_BAR_DW)) |-> (cfg_rdata == 32'd0));

    assert_id_constant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == AW'(DW_ID)) |-> (cfg_rdata == {DEVICE_ID, VENDOR_ID}));

endmodule

// File: tb/cfg_header_regs_tb.sv
module cfg_header_regs_tb;

    localparam int NB = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [5:0]        cfg_addr = '0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [5:0]        err_evt = '0;
    logic              io_decode_en, mem_decode_en, master_en;
    logic [NB-1:0]     region_en, region_remap;
    logic [64*NB-1:0]  region_base, region_size;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cfg_header_regs #(
        .VENDOR_ID (16'h1AB3),
        .DEVICE_ID (16'h7C21),
        .REVISION  (8'h05),
        .CLASS_CODE(24'h020000),
        .CMD_WMASK (16'hFC37),
        .STAT_INIT (16'h02B0),
        .STAT_WMASK(16'hF900),
        .NB        (NB),
        .BAR_KIND  (12'h239),
        .BAR_LOG2  ({6'd0, 6'd16, 6'd0, 6'd34, 6'd12, 6'd5}),
        .BAR_PREF  (6'b010100)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_be       (cfg_be),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .err_evt      (err_evt),
        .io_decode_en (io_decode_en),
        .mem_decode_en(mem_decode_en),
        .master_en    (master_en),
        .region_en    (region_en),
        .region_remap (region_remap),
        .region_base  (region_base),
        .region_size  (region_size)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ev(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                         input logic [5:0] ev);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; err_evt = ev;
        @(negedge clk);
        cfg_wr = 1'b0; err_evt = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        wr_ev(a, be, d, 6'd0);
    endtask

    task automatic pulse_ev(input logic [5:0] ev);
        @(negedge clk);
        err_evt = ev;
        @(negedge clk);
        err_evt = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic int evpos(input int k);
        return (k == 0) ? 8 : 10 + k;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R1 identification, R2 command, R4 status.
        rd(6'd0, d); check("R1 id dword", d, 32'h7C21_1AB3);
        rd(6'd2, d); check("R1 class/rev", d, 32'h0200_0005);
        rd(6'd3, d); check("R1 header type", d, 32'h0);
        rd(6'd1, d); check("R2 R4 reset cmd/stat", d, 32'h02B0_0000);
        check("R3 reset enables", {master_en, mem_decode_en, io_decode_en, region_en}, '0);

        // R1 and R9: writes to identity and reserved dwords are discarded.
        wr(6'd0, 4'hF, 32'hFFFF_FFFF);
        wr(6'd2, 4'hF, 32'hFFFF_FFFF);
        wr(6'd3, 4'hF, 32'hFFFF_FFFF);
        for (int a = 10; a < 64; a++) wr(6'(a), 4'hF, 32'hFFFF_FFFF);
        rd(6'd0, d); check("R1 id after write", d, 32'h7C21_1AB3);
        rd(6'd2, d); check("R1 class after write", d, 32'h0200_0005);
        rd(6'd3, d); check("R9 dword3 after write", d, 32'h0);
        for (int a = 10; a < 64; a++) begin
            rd(6'(a), d); check("R9 reserved read", d, 32'h0);
        end
        rd(6'd1, d); check("R9 cmd/stat untouched", d, 32'h02B0_0000);

        // R2 sweep of every command bit; R11 status untouched.
        for (int k = 0; k < 16; k++) begin
            wr(6'd1, 4'b0011, 32'hFFFF_0000 | (32'd1 << k));
            rd(6'd1, d);
            check("R2 cmd bit sweep", d[15:0], 16'((32'd1 << k) & 32'h37));
            check("R11 stat untouched by cmd write", d[31:16], 16'h02B0);
        end
        wr(6'd1, 4'b0011, 32'h0000_FFFF);
        rd(6'd1, d); check("R2 cmd all ones", d[15:0], 16'h0037);
        wr(6'd1, 4'b0010, 32'h0000_0000);
        rd(6'd1, d); check("R11 cmd high byte only", d[15:0], 16'h0037);
        wr(6'd1, 4'b0001, 32'h0000_0000);
        rd(6'd1, d); check("R11 cmd low byte cleared", d[15:0], 16'h0000);

        // R3: decode enables for every combination of bits 2..0.
        for (int c = 0; c < 8; c++) begin
            logic [5:0] exp_en;
            wr(6'd1, 4'b0011, 32'(c));
            exp_en = {1'b0, c[1], 1'b0, c[1], c[1], c[0]};
            #1;
            check("R3 io decode", io_decode_en, c[0]);
            check("R3 mem decode", mem_decode_en, c[1]);
            check("R3 master", master_en, c[2]);
            check("R3 region enables", region_en, exp_en);
        end
        wr(6'd1, 4'b0011, 32'h0);

        // R6 R7 R8: size probing with decode disabled.
        for (int s = 0; s < NB; s++) begin
            wr(6'(4 + s), 4'hF, 32'hFFFF_FFFF);
            #1; check("R10 no remap when disabled", region_remap, '0);
        end
        rd(6'd4, d); check("R6 io probe", d, 32'hFFFF_FFE1);
        rd(6'd5, d); check("R7 mem32 probe", d, 32'hFFFF_F000);
        rd(6'd6, d); check("R8 mem64 low probe", d, 32'h0000_000C);
        rd(6'd7, d); check("R8 mem64 high probe", d, 32'hFFFF_FFFC);
        rd(6'd8, d); check("R7 mem32 prefetch probe", d, 32'hFFFF_0008);
        rd(6'd9, d); check("R9 unused slot", d, 32'h0);
        check("R6 io size", region_size[0 +: 64], 64'd32);
        check("R7 mem32 size", region_size[64 +: 64], 64'h1000);
        check("R8 mem64 size", region_size[128 +: 64], 64'h4_0000_0000);
        check("R7 mem32 pref size", region_size[256 +: 64], 64'h1_0000);
        check("R10 base after probe", region_base[64 +: 64], 64'hFFFF_F000);
        wr(6'd4, 4'hF, 32'h0000_1234);
        rd(6'd4, d); check("R6 io low bits", d, 32'h0000_1221);

        // R10: partial writes, remap pulse, unchanged and disabled cases.
        wr(6'd1, 4'b0011, 32'h2);
        wr(6'd5, 4'b0011, 32'hABCD_5000);
        #1; check("R10 partial no remap", region_remap, '0);
        check("R10 partial keeps base", region_base[64 +: 64], 64'hFFFF_F000);
        wr(6'd5, 4'b1100, 32'hABCD_5000);
        #1; check("R10 remap pulse", region_remap, 6'b000010);
        check("R10 new base", region_base[64 +: 64], 64'hABCD_5000);
        @(negedge clk); #1;
        check("R10 pulse one cycle", region_remap, '0);
        wr(6'd5, 4'hF, 32'hABCD_5000);
        #1; check("R10 unchanged no remap", region_remap, '0);
        wr(6'd1, 4'b0011, 32'h1);
        wr(6'd5, 4'hF, 32'h1000_0000);
        #1; check("R10 mem disabled no remap", region_remap, '0);
        check("R10 base still published", region_base[64 +: 64], 64'h1000_0000);
        wr(6'd4, 4'hF, 32'h0000_2000);
        #1; check("R10 io remap", region_remap, 6'b000001);
        check("R10 io base", region_base[0 +: 64], 64'h2000);
        wr(6'd1, 4'b0011, 32'h2);
        wr(6'd7, 4'hF, 32'h0000_0004);
        #1; check("R8 R10 mem64 high remap", region_remap, 6'b000100);
        check("R8 mem64 base", region_base[128 +: 64], 64'h0000_0004_0000_0000);

        // R4 R5: per-event set, write-zero keeps, write-one clears.
        for (int k = 0; k < 6; k++) begin
            st = 16'h02B0 | 16'(32'd1 << evpos(k));
            pulse_ev(6'(32'd1 << k));
            rd(6'd1, d); check("R5 event sets bit", d[31:16], st);
            wr(6'd1, 4'b1100, 32'h0);
            rd(6'd1, d); check("R4 write zero keeps", d[31:16], st);
            wr(6'd1, 4'b1100, 32'(32'd1 << (evpos(k) + 16)));
            rd(6'd1, d); check("R4 write one clears", d[31:16], 16'h02B0);
        end
        pulse_ev(6'h3F);
        rd(6'd1, d); check("R5 all events", d[31:16], 16'hFBB0);
        wr(6'd1, 4'b0100, 32'hFFFF_0000);
        rd(6'd1, d); check("R11 status low byte write", d[31:16], 16'hFBB0);
        wr(6'd1, 4'b1000, 32'hFFFF_0000);
        rd(6'd1, d); check("R4 read-only bits kept", d[31:16], 16'h02B0);
        check("R11 cmd untouched by status write", d[15:0], 16'h0002);
        pulse_ev(6'b000010);
        wr_ev(6'd1, 4'b1100, 32'h0800_0000, 6'b000010);
        rd(6'd1, d); check("R5 set wins over clear", d[31:16], 16'h0AB0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule